// File: doc/BRIEF.md
# Paged Physical Address Generator

This block turns a 16-bit logical address into a 19-bit physical address for a small 16-bit processor. The top three address bits select one of eight 64 KB pages. The block keeps the status word, whose upper nine bits hold three page fields: one for code, one for data and one for stack. It also keeps a separate 3-bit page register that only cross-page data moves use. Each access names its kind, and the block attaches the matching page to the logical address.

The block also owns the program counter and the stack pointer, so that a page jump can change the code page and the program counter in one operation. One command is applied per clock. The commands set a single page field, load the whole status word (for example on a return from a handler), enter a handler vector, jump within the current page, step the program counter, or load the stack pointer. The physical address output is combinational from the registered state, so a command changes the address that accesses see from the following cycle onward.

Top module: `paged_addr_gen`

## Requirements
- R1: With `kind` = 0 (code), `phys_addr` equals {`sr_q`[15:13], `log_addr`}.
- R2: With `kind` = 1 (data), `phys_addr` equals {`sr_q`[12:10], `log_addr`}.
- R3: With `kind` = 2 (stack), `phys_addr` equals {`sr_q`[9:7], `log_addr`}.
- R4: With `kind` = 3 (cross-page move), `phys_addr` equals {`odp_q`, `log_addr`}, and the data page field plays no part.
- R5: While `rst_n` is low and after it is released, `sr_q` is 0, `odp_q` is 0, `pc_q` is 0x0020 and `sp_q` is 0xFFFE. This puts all three pages at 0.
- R6: `op` 1, 2 and 3 write `op_val`[2:0] into `sr_q`[12:10], `sr_q`[9:7] and `odp_q` respectively. Bits 15:3 of `op_val` are ignored, and every other bit of `sr_q` is kept.
- R7: `op` 4 (page jump) loads `op_val`[2:0] into `sr_q`[15:13] and `op_tgt` into `pc_q` on the same edge. `fetch_addr` is always {`sr_q`[15:13], `pc_q`}.
- R8: A command changes neither `phys_addr` nor `fetch_addr` in the cycle in which it is presented. The new page is used from the next cycle.
- R9: `op` 5 loads `op_val` into the whole of `sr_q`.
- R10: `op` 6 (vector entry) clears `sr_q`[15:13], loads `op_tgt` into `pc_q` and keeps `sr_q`[12:0].
- R11: `op` 7 loads `op_tgt` into `pc_q` and keeps the code page. `op` 8 adds 2 to `pc_q`, wraps within 16 bits and leaves the code page unchanged.
- R12: `op` 9 loads `op_val` into `sp_q`. `op` 0 and the unused codes 10 to 15 leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 4 | Command applied at the next edge |
| kind | input | 2 | Access kind: 0 code, 1 data, 2 stack, 3 cross-page |
| log_addr | input | 16 | Logical address of the current access |
| op_val | input | 16 | Page operand, status word or stack pointer value |
| op_tgt | input | 16 | Jump target or vector address |
| phys_addr | output | 19 | Physical address of the current access |
| fetch_addr | output | 19 | Physical address of the next instruction fetch |
| sr_q | output | 16 | Status word holding the three page fields |
| odp_q | output | 3 | Cross-page move page register |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |

## Verification
The bench builds the block with its default parameters: reset program counter 0x0020, reset stack pointer 0xFFFE and a step of 2. With these values the reset state and the wrap of the program counter from 0xFFFE to 0x0000 can be checked. The wrap is reached by jumping to the last word of a page and stepping once. Random operands with nonzero upper bits cover the masking of page operands. Commands are paired with accesses of the same kind in the same cycle, which exposes any page write that shows through too early.

// File: rtl/pag_pkg.sv
// Package: shared encodings and field positions for the paged address generator.
// Assumes a 16-bit status word with three 3-bit page fields in its upper bits.
package pag_pkg;
    localparam int LADDR_W   = 16;
    localparam int PAGE_W    = 3;
    localparam int PADDR_W   = LADDR_W + PAGE_W;
    localparam int CODE_LSB  = 13;
    localparam int DATA_LSB  = 10;
    localparam int STACK_LSB = 7;

    typedef enum logic [1:0] {
        KIND_CODE  = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_STACK = 2'd2,
        KIND_XPAGE = 2'd3
    } kind_e;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_SET_DP  = 4'd1,
        OP_SET_SP  = 4'd2,
        OP_SET_ODP = 4'd3,
        OP_PJMP    = 4'd4,
        OP_SR_LD   = 4'd5,
        OP_VEC     = 4'd6,
        OP_JMP     = 4'd7,
        OP_STEP    = 4'd8,
        OP_SP_LD   = 4'd9
    } op_e;
endpackage

// File: rtl/pag_page_regs.sv
// Module: holds the status word and the cross-page register.
// Applies one page or status command per clock. Codes it does not own leave both
// registers unchanged. Only the low PAGE_W bits of a page operand are used.
module pag_page_regs
    import pag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         op,
    input  logic [LADDR_W-1:0] op_val,
    output logic [LADDR_W-1:0] sr_q,
    output logic [PAGE_W-1:0]  odp_q
);
    logic [PAGE_W-1:0] page_opnd;

    // Purpose: keep only the page-number bits of the operand.
    always_comb page_opnd = op_val[PAGE_W-1:0];

    // Purpose: update the status word fields according to the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            unique case (op)
                OP_SET_DP:  sr_q[DATA_LSB  +: PAGE_W] <= page_opnd;
                OP_SET_SP:  sr_q[STACK_LSB +: PAGE_W] <= page_opnd;
                OP_PJMP:    sr_q[CODE_LSB  +: PAGE_W] <= page_opnd;
                OP_VEC:     sr_q[CODE_LSB  +: PAGE_W] <= '0;
                OP_SR_LD:   sr_q <= op_val;
                default:    sr_q <= sr_q;
            endcase
        end
    end

    // Purpose: update the cross-page register on its own command only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odp_q <= '0;
        end else if (op == OP_SET_ODP) begin
            odp_q <= page_opnd;
        end
    end
endmodule

// File: rtl/pag_ptr_regs.sv
// Module: program counter and stack pointer.
// Assumes PC_STEP fits in LADDR_W bits. The counter wraps inside the 16-bit
// logical space and never touches a page field.
module pag_ptr_regs
    import pag_pkg::*;
#(
    parameter logic [LADDR_W-1:0] RESET_PC = 16'h0020,
    parameter logic [LADDR_W-1:0] RESET_SP = 16'hFFFE,
    parameter logic [LADDR_W-1:0] PC_STEP  = 16'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         op,
    input  logic [LADDR_W-1:0] op_val,
    input  logic [LADDR_W-1:0] op_tgt,
    output logic [LADDR_W-1:0] pc_q,
    output logic [LADDR_W-1:0] sp_q
);
    // Purpose: load, step or hold the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            unique case (op)
                OP_PJMP, OP_VEC, OP_JMP: pc_q <= op_tgt;
                OP_STEP:                 pc_q <= pc_q + PC_STEP;
                default:                 pc_q <= pc_q;
            endcase
        end
    end

    // Purpose: load or hold the stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= RESET_SP;
        end else if (op == OP_SP_LD) begin
            sp_q <= op_val;
        end
    end
endmodule

// File: rtl/pag_addr_sel.sv
// Module: combinational page selection.
// Picks the page for the access kind and places it above the logical address.
// Assumes the status word and cross-page register are already registered, so a
// command presented this cycle cannot reach the output until the next cycle.
module pag_addr_sel
    import pag_pkg::*;
(
    input  logic [1:0]         kind,
    input  logic [LADDR_W-1:0] log_addr,
    input  logic [LADDR_W-1:0] sr_q,
    input  logic [PAGE_W-1:0]  odp_q,
    input  logic [LADDR_W-1:0] pc_q,
    output logic [PADDR_W-1:0] phys_addr,
    output logic [PADDR_W-1:0] fetch_addr
);
    logic [PAGE_W-1:0] code_pg;
    logic [PAGE_W-1:0] data_pg;
    logic [PAGE_W-1:0] stack_pg;
    logic [PAGE_W-1:0] sel_pg;

    // Purpose: split the status word into its three page fields.
    always_comb begin
        code_pg  = sr_q[CODE_LSB  +: PAGE_W];
        data_pg  = sr_q[DATA_LSB  +: PAGE_W];
        stack_pg = sr_q[STACK_LSB +: PAGE_W];
    end

    // Purpose: choose the page that matches the access kind.
    always_comb begin
        unique case (kind)
            KIND_CODE:  sel_pg = code_pg;
            KIND_DATA:  sel_pg = data_pg;
            KIND_STACK: sel_pg = stack_pg;
            default:    sel_pg = odp_q;
        endcase
    end

    // Purpose: form the access address and the fetch address.
    always_comb begin
        phys_addr  = {sel_pg, log_addr};
        fetch_addr = {code_pg, pc_q};
    end
endmodule

// File: rtl/paged_addr_gen.sv
// Module: top of the paged physical address generator.
// Wires the page registers, the pointer registers and the page selector.
// Assumes one command per clock and a synchronous active-low reset.
module paged_addr_gen
    import pag_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0020,
    parameter logic [15:0] RESET_SP = 16'hFFFE,
    parameter logic [15:0] PC_STEP  = 16'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  op,
    input  logic [1:0]  kind,
    input  logic [15:0] log_addr,
    input  logic [15:0] op_val,
    input  logic [15:0] op_tgt,
    output logic [18:0] phys_addr,
    output logic [18:0] fetch_addr,
    output logic [15:0] sr_q,
    output logic [2:0]  odp_q,
    output logic [15:0] pc_q,
    output logic [15:0] sp_q
);
    pag_page_regs u_pages (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .op_val (op_val),
        .sr_q   (sr_q),
        .odp_q  (odp_q)
    );

    pag_ptr_regs #(
        .RESET_PC (RESET_PC),
        .RESET_SP (RESET_SP),
        .PC_STEP  (PC_STEP)
    ) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .op_val (op_val),
        .op_tgt (op_tgt),
        .pc_q   (pc_q),
        .sp_q   (sp_q)
    );

    pag_addr_sel u_sel (
        .kind       (kind),
        .log_addr   (log_addr),
        .sr_q       (sr_q),
        .odp_q      (odp_q),
        .pc_q       (pc_q),
        .phys_addr  (phys_addr),
        .fetch_addr (fetch_addr)
    );
endmodule

// File: rtl/paged_addr_gen_chk.sv
// Checker: temporal properties of the paged address generator, bound to the top.
// Assumes reset is held low for at least one edge before it is released.
module paged_addr_gen_chk #(
    parameter logic [15:0] RESET_PC = 16'h0020,
    parameter logic [15:0] RESET_SP = 16'hFFFE,
    parameter logic [15:0] PC_STEP  = 16'd2
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op,
    input logic [1:0]  kind,
    input logic [15:0] log_addr,
    input logic [15:0] op_val,
    input logic [15:0] op_tgt,
    input logic [18:0] phys_addr,
    input logic [18:0] fetch_addr,
    input logic [15:0] sr_q,
    input logic [2:0]  odp_q,
    input logic [15:0] pc_q,
    input logic [15:0] sp_q
);
    a_r1_code_page: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd0) |-> (phys_addr == {sr_q[15:13], log_addr}));
    a_r2_data_page: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd1) |-> (phys_addr == {sr_q[12:10], log_addr}));
    a_r3_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd2) |-> (phys_addr == {sr_q[9:7], log_addr}));
    a_r4_xpage: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd3) |-> (phys_addr == {odp_q, log_addr}));
    a_r5_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sr_q == 16'h0 && odp_q == 3'h0 && pc_q == RESET_PC && sp_q == RESET_SP));
    a_r6_set_data: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd1) |=> (sr_q[12:10] == $past(op_val[2:0]) && sr_q[15:13] == $past(sr_q[15:13])
                          && sr_q[9:0] == $past(sr_q[9:0])));
    a_r6_set_odp: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd3) |=> (odp_q == $past(op_val[2:0]) && $stable(sr_q)));
    a_r7_page_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd4) |=> (fetch_addr == {$past(op_val[2:0]), $past(op_tgt)}));
    a_r8_no_early_page: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd1 && kind == 2'd1) |-> (phys_addr[18:16] == sr_q[12:10]));
    a_r10_vector_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd6) |=> (sr_q[15:13] == 3'd0 && pc_q == $past(op_tgt) && sr_q[12:0] == $past(sr_q[12:0])));
    a_r11_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd8) |=> (pc_q == $past(pc_q) + PC_STEP && $stable(sr_q)));
    a_r12_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd0) |=> ($stable(sr_q) && $stable(odp_q) && $stable(pc_q) && $stable(sp_q)));
endmodule

bind paged_addr_gen paged_addr_gen_chk #(
    .RESET_PC (RESET_PC),
    .RESET_SP (RESET_SP),
    .PC_STEP  (PC_STEP)
) chk (.*);

// File: tb/paged_addr_gen_test.sv
// Bench: random commands and accesses checked against a model kept in the bench.
module paged_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [1:0]  kind = 2'd0;
    logic [15:0] log_addr = 16'h0;
    logic [15:0] op_val = 16'h0;
    logic [15:0] op_tgt = 16'h0;
    logic [18:0] phys_addr, fetch_addr;
    logic [15:0] sr_q, pc_q, sp_q;
    logic [2:0]  odp_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_sr, m_pc, m_sp;
    logic [2:0]  m_odp;

    paged_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .op(op), .kind(kind), .log_addr(log_addr),
        .op_val(op_val), .op_tgt(op_tgt), .phys_addr(phys_addr), .fetch_addr(fetch_addr),
        .sr_q(sr_q), .odp_q(odp_q), .pc_q(pc_q), .sp_q(sp_q)
    );

    always #4ns clk = ~clk;

    initial begin
        #(8ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired: actual hung, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    function automatic logic [18:0] exp_phys(input logic [1:0] k, input logic [15:0] a,
                                             input logic [15:0] s, input logic [2:0] o);
        case (k)
            2'd0:    return {s[15:13], a};
            2'd1:    return {s[12:10], a};
            2'd2:    return {s[9:7], a};
            default: return {o, a};
        endcase
    endfunction

    function automatic string req_of_kind(input logic [1:0] k);
        case (k)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string req_of_op(input logic [3:0] o);
        case (o)
            4'd1, 4'd2, 4'd3: return "R6";
            4'd4: return "R7";
            4'd5: return "R9";
            4'd6: return "R10";
            4'd7, 4'd8: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model update for one command.
    task automatic model_step(input logic [3:0] o, input logic [15:0] v, input logic [15:0] t);
        case (o)
            4'd1: m_sr[12:10] = v[2:0];
            4'd2: m_sr[9:7]   = v[2:0];
            4'd3: m_odp       = v[2:0];
            4'd4: begin m_sr[15:13] = v[2:0]; m_pc = t; end
            4'd5: m_sr = v;
            4'd6: begin m_sr[15:13] = 3'd0; m_pc = t; end
            4'd7: m_pc = t;
            4'd8: m_pc = m_pc + 16'd2;
            4'd9: m_sp = v;
            default: ;
        endcase
    endtask

    // Apply one command with one access; check the access before the edge
    // and the registers after it.
    task automatic cycle(input logic [3:0] o, input logic [1:0] k, input logic [15:0] a,
                         input logic [15:0] v, input logic [15:0] t);
        op = o; kind = k; log_addr = a; op_val = v; op_tgt = t;
        #1;
        check(req_of_kind(k), 64'(phys_addr), 64'(exp_phys(k, a, m_sr, m_odp)));
        check("R8", 64'(fetch_addr), 64'({m_sr[15:13], m_pc}));
        @(posedge clk);
        model_step(o, v, t);
        @(negedge clk);
        check(req_of_op(o), {m_sr, m_pc, m_sp, 13'd0, m_odp} & 64'hFFFFFFFFFFFFFFFF,
              {sr_q, pc_q, sp_q, 13'd0, odp_q});
        check(req_of_op(o), 64'(fetch_addr), 64'({m_sr[15:13], m_pc}));
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        m_sr = 16'h0; m_pc = 16'h0020; m_sp = 16'hFFFE; m_odp = 3'd0;
        repeat (3) @(negedge clk);
        // R5: state held in reset
        check("R5", 64'({sr_q, pc_q, sp_q, 13'd0, odp_q}), 64'({16'h0, 16'h0020, 16'hFFFE, 16'h0}));
        rst_n = 1'b1;
        @(negedge clk);
        check("R5", 64'(fetch_addr), 64'h0020);
        // Directed: operand upper bits ignored (R6), same-cycle invisibility (R8)
        cycle(4'd1, 2'd1, 16'h1234, 16'hFFF9, 16'h0);
        check("R6", 64'(sr_q[12:10]), 64'd1);
        cycle(4'd2, 2'd2, 16'h00FE, 16'hABCE, 16'h0);
        cycle(4'd3, 2'd3, 16'h4000, 16'h8005, 16'h0);
        cycle(4'd0, 2'd3, 16'h4000, 16'h0, 16'h0);
        check("R4", 64'(phys_addr), 64'h54000);
        // R7 page jump then R11 wrap at page end
        cycle(4'd4, 2'd0, 16'h0100, 16'h0006, 16'hFFFE);
        check("R7", 64'(fetch_addr), 64'h6FFFE);
        cycle(4'd8, 2'd0, 16'h0100, 16'h0, 16'h0);
        check("R11", 64'(fetch_addr), 64'h60000);
        // R10 vector entry clears the code page
        cycle(4'd6, 2'd0, 16'h0, 16'h0, 16'h0008);
        check("R10", 64'(fetch_addr), 64'h00008);
        // R9 full status load restores all pages
        cycle(4'd5, 2'd2, 16'h0, 16'hFFFF, 16'h0);
        cycle(4'd12, 2'd0, 16'hBEEF, 16'h1111, 16'h2222);
        check("R9", 64'(phys_addr), 64'h7BEEF);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 15));
            cycle(ro, 2'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule